// File: doc/BRIEF.md
# Boot Space Selector with Low-Address Alias

This block decides, after every reset and after every return from standby, which of three memories the processor boots from: main flash, the system (loader) memory, or on-chip SRAM. The choice comes from an external boot pin and a stored option bit. These inputs are captured on a fixed rising clock edge after reset release. Until that edge the block holds the processor off with a not-ready output. After that edge the first fetch goes to address 0x0000_0000 and the reset vector is read from 0x0000_0004.

The block also maps addresses. Any address inside a low alias window is translated onto the base of the memory currently mapped there. Addresses outside the window pass through unchanged. Each memory therefore stays reachable at its own base as well. An empty-flash flag is refreshed only when the option bytes are loaded. While it is set, a boot that would go to main flash goes to the system memory instead, so that a blank part can be programmed. After boot, software may move the alias onto a different memory with a two-bit mapping write.

Top module: `boot_alias_ctrl`

## Requirements
- R1: `cpu_hold` is 1 from reset until the 4th rising clock edge after reset release (or after a standby exit), falls at that edge, and stays 0 until the next standby exit.
- R2: At the latching edge, `boot_sel` takes the decoded value: boot pin 0 gives flash (00); pin 1 with option bit 1 gives system memory (01); pin 1 with option bit 0 gives SRAM (11).
- R3: `empty_flag` changes only on a clock edge where `opt_load` is 1. It then becomes 1 when `flash_word0` is 0xFFFF_FFFF and 0 otherwise. Its reset value is 0.
- R4: When `empty_flag` is 1 and the pin selects flash, the latched selection is system memory (01). The SRAM and system-memory cases are unaffected.
- R5: For `addr_in` below `WIN_BYTES`, `addr_out` equals the mapped memory's base plus `addr_in`. The bases are flash 0x0800_0000, SRAM 0x2000_0000, and system memory `SYS_BASE`.
- R6: For `addr_in` at or above `WIN_BYTES`, `addr_out` equals `addr_in`.
- R7: With `cpu_hold` at 0, a `remap_we` edge loads `remap_val` into the alias mapping. The encoding is 00 flash, 01 system memory, 11 SRAM, and 10 acts as flash. `boot_sel` does not change.
- R8: Mapping writes made while `cpu_hold` is 1 are ignored.
- R9: `standby_exit` raises `cpu_hold` and restarts the edge count. At the 4th following edge, the pins are re-sampled and the alias mapping is reinitialised to the new selection.
- R10: Pin or option-bit changes after the latching edge do not affect `boot_sel` until the next re-sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pin | input | 1 | External boot select pin |
| boot_opt | input | 1 | Stored boot option bit |
| opt_load | input | 1 | Option-byte load strobe |
| flash_word0 | input | 32 | First word of main flash |
| standby_exit | input | 1 | Pulse on return from standby |
| remap_we | input | 1 | Alias mapping write strobe |
| remap_val | input | 2 | New alias mapping value |
| addr_in | input | AW | Bus address from the processor |
| addr_out | output | AW | Translated address |
| boot_sel | output | 2 | Latched boot selection |
| empty_flag | output | 1 | Main flash considered blank |
| cpu_hold | output | 1 | Processor not ready to fetch |

## Verification
A wrong edge count shows at the ports on the release cycle itself: `cpu_hold` falls one edge early or late. A wrong decoded selection shows on `boot_sel` in the same cycle. A corrupted alias mapping is not visible on `boot_sel`. It appears on the next aliased address as a wrong base on `addr_out`, which is combinational and so has no added delay. A stale or wrongly updated empty flag shows on `empty_flag` one edge after an option load. It then surfaces as a wrong boot space at the next re-sample.

// File: rtl/boot_alias_ctrl.sv
module boot_alias_ctrl #(
  parameter int AW = 32,
  parameter logic [AW-1:0] FLASH_BASE = 32'h0800_0000,
  parameter logic [AW-1:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [AW-1:0] SYS_BASE   = 32'h1FFF_EC00,
  parameter logic [AW-1:0] WIN_BYTES  = 32'h0000_8000,
  parameter int LATCH_EDGE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_pin,
  input  logic          boot_opt,
  input  logic          opt_load,
  input  logic [31:0]   flash_word0,
  input  logic          standby_exit,
  input  logic          remap_we,
  input  logic [1:0]    remap_val,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    boot_sel,
  output logic          empty_flag,
  output logic          cpu_hold
);
  localparam int CW = $clog2(LATCH_EDGE + 1);
  localparam logic [CW-1:0] LAST = CW'(LATCH_EDGE - 1);
  localparam logic [1:0] SEL_FLASH = 2'b00;
  localparam logic [1:0] SEL_SYS   = 2'b01;
  localparam logic [1:0] SEL_SRAM  = 2'b11;

  logic [CW-1:0] edge_cnt;
  logic [1:0]    mem_mode;
  logic [1:0]    pin_sel;
  logic [AW-1:0] alias_base;

  assign pin_sel = !boot_pin ? (empty_flag ? SEL_SYS : SEL_FLASH)
                             : (boot_opt   ? SEL_SYS : SEL_SRAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt   <= '0;
      cpu_hold   <= 1'b1;
      boot_sel   <= SEL_FLASH;
      mem_mode   <= SEL_FLASH;
      empty_flag <= 1'b0;
    end else begin
      if (opt_load)
        empty_flag <= &flash_word0;
      if (standby_exit) begin
        cpu_hold <= 1'b1;
        edge_cnt <= '0;
      end else if (cpu_hold) begin
        if (edge_cnt == LAST) begin
          cpu_hold <= 1'b0;
          boot_sel <= pin_sel;
          mem_mode <= pin_sel;
          edge_cnt <= '0;
        end else begin
          edge_cnt <= edge_cnt + 1'b1;
        end
      end else if (remap_we) begin
        mem_mode <= remap_val;
      end
    end
  end

  always_comb begin
    case (mem_mode)
      SEL_SYS:  alias_base = SYS_BASE;
      SEL_SRAM: alias_base = SRAM_BASE;
      default:  alias_base = FLASH_BASE;
    endcase
  end

  assign addr_out = (addr_in < WIN_BYTES) ? alias_base + addr_in : addr_in;
endmodule

// File: rtl/boot_alias_ctrl_chk.sv
module boot_alias_ctrl_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] WIN_BYTES = 32'h0000_8000,
  parameter int LATCH_EDGE = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boot_pin,
  input logic          boot_opt,
  input logic          opt_load,
  input logic [31:0]   flash_word0,
  input logic          standby_exit,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic [1:0]    boot_sel,
  input logic          empty_flag,
  input logic          cpu_hold
);
  int seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 0;
    else if (standby_exit || !cpu_hold) seen <= 0;
    else seen <= seen + 1;
  end

  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && !standby_exit && seen == LATCH_EDGE - 1) |=> !cpu_hold);

  assert_stays_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold && !standby_exit) |=> !cpu_hold);

  assert_early_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && seen < LATCH_EDGE - 1) |=> cpu_hold);

  assert_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |->
      boot_sel == (!$past(boot_pin) ? ($past(empty_flag) ? 2'b01 : 2'b00)
                                    : ($past(boot_opt) ? 2'b01 : 2'b11)));

  assert_empty_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_load |=> $stable(empty_flag));

  assert_empty_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    opt_load |=> empty_flag == ($past(flash_word0) == 32'hFFFF_FFFF));

  assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_in >= WIN_BYTES) |-> addr_out == addr_in);

  assert_sel_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold && !standby_exit) |=> $stable(boot_sel));
endmodule

bind boot_alias_ctrl boot_alias_ctrl_chk #(
  .AW(AW), .WIN_BYTES(WIN_BYTES), .LATCH_EDGE(LATCH_EDGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .boot_opt(boot_opt),
  .opt_load(opt_load), .flash_word0(flash_word0), .standby_exit(standby_exit),
  .addr_in(addr_in), .addr_out(addr_out), .boot_sel(boot_sel),
  .empty_flag(empty_flag), .cpu_hold(cpu_hold)
);

// File: tb/boot_alias_ctrl_tb.sv
module boot_alias_ctrl_tb;
  localparam logic [31:0] FLASH = 32'h0800_0000;
  localparam logic [31:0] SRAM  = 32'h2000_0000;
  localparam logic [31:0] SYSB  = 32'h1FFF_EC00;
  localparam logic [31:0] WIN   = 32'h0000_8000;

  logic clk = 0, rst_n = 0;
  logic boot_pin = 0, boot_opt = 0, opt_load = 0, standby_exit = 0, remap_we = 0;
  logic [31:0] flash_word0 = 0, addr_in = 0;
  logic [1:0] remap_val = 0;
  logic [31:0] addr_out;
  logic [1:0] boot_sel;
  logic empty_flag, cpu_hold;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  boot_alias_ctrl u_dut (.clk(clk), .rst_n(rst_n), .boot_pin(boot_pin),
    .boot_opt(boot_opt), .opt_load(opt_load), .flash_word0(flash_word0),
    .standby_exit(standby_exit), .remap_we(remap_we), .remap_val(remap_val),
    .addr_in(addr_in), .addr_out(addr_out), .boot_sel(boot_sel),
    .empty_flag(empty_flag), .cpu_hold(cpu_hold));

  // reference model
  bit m_hold = 1, m_empty = 0;
  int m_edges = 0;
  logic [1:0] m_sel = 0, m_mode = 0;

  function automatic logic [31:0] exp_addr(logic [1:0] mode, logic [31:0] a);
    logic [31:0] b;
    if (a >= WIN) return a;
    b = (mode == 2'b01) ? SYSB : (mode == 2'b11) ? SRAM : FLASH;
    return b + a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold <= 1; m_edges <= 0; m_sel <= 0; m_mode <= 0; m_empty <= 0;
    end else begin
      logic [1:0] s;
      if (!boot_pin) s = m_empty ? 2'b01 : 2'b00;
      else s = boot_opt ? 2'b01 : 2'b11;
      if (opt_load) m_empty <= (flash_word0 == 32'hFFFF_FFFF);
      if (standby_exit) begin m_hold <= 1; m_edges <= 0; end
      else if (m_hold) begin
        if (m_edges + 1 == 4) begin m_hold <= 0; m_sel <= s; m_mode <= s; m_edges <= 0; end
        else m_edges <= m_edges + 1;
      end else if (remap_we) m_mode <= remap_val;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R1 model", {31'd0, cpu_hold}, {31'd0, m_hold});
    chk("R2 model", {30'd0, boot_sel}, {30'd0, m_sel});
    chk("R3 model", {31'd0, empty_flag}, {31'd0, m_empty});
    chk("R5 model", addr_out, exp_addr(m_mode, addr_in));
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic look();
    @(negedge clk);
    #1;
  endtask

  task automatic resample();
    standby_exit = 1; tick(1); standby_exit = 0; tick(4);
  endtask

  task automatic remap(logic [1:0] v);
    remap_we = 1; remap_val = v; tick(1); remap_we = 0;
  endtask

  initial begin
    tick(3);
    look(); chk("R1 reset hold", {31'd0, cpu_hold}, 1);
    chk("R3 reset empty", {31'd0, empty_flag}, 0);
    rst_n = 1;
    tick(3); look(); chk("R1 hold before 4th edge", {31'd0, cpu_hold}, 1);
    tick(1); look(); chk("R1 released at 4th edge", {31'd0, cpu_hold}, 0);
    chk("R2 pin0 flash", {30'd0, boot_sel}, 0);
    addr_in = 32'h4; look(); chk("R5 vector flash", addr_out, FLASH + 4);
    addr_in = WIN - 1; look(); chk("R5 window top", addr_out, FLASH + WIN - 1);
    addr_in = WIN; look(); chk("R6 window edge", addr_out, WIN);
    addr_in = SRAM + 32'h40; look(); chk("R6 native sram", addr_out, SRAM + 32'h40);
    addr_in = 32'h10;
    remap(2'b11); look(); chk("R7 remap sram", addr_out, SRAM + 32'h10);
    chk("R7 boot_sel kept", {30'd0, boot_sel}, 0);
    remap(2'b10); look(); chk("R7 code 10 flash", addr_out, FLASH + 32'h10);
    remap(2'b01); look(); chk("R7 remap sys", addr_out, SYSB + 32'h10);
    boot_pin = 1; boot_opt = 1; tick(2); look();
    chk("R10 pins ignored", {30'd0, boot_sel}, 0);
    standby_exit = 1; tick(1); standby_exit = 0; look();
    chk("R9 hold on standby exit", {31'd0, cpu_hold}, 1);
    remap(2'b11); look(); chk("R8 remap during hold ignored", addr_out, SYSB + 32'h10);
    tick(2); look(); chk("R9 still held", {31'd0, cpu_hold}, 1);
    tick(1); look(); chk("R9 released", {31'd0, cpu_hold}, 0);
    chk("R9 resampled sys", {30'd0, boot_sel}, 2'b01);
    flash_word0 = 32'hFFFF_FFFF; opt_load = 1; tick(1); opt_load = 0; look();
    chk("R3 empty set", {31'd0, empty_flag}, 1);
    boot_pin = 0; resample(); look();
    chk("R4 empty redirects", {30'd0, boot_sel}, 2'b01);
    boot_pin = 1; boot_opt = 0; resample(); look();
    chk("R4 sram unaffected", {30'd0, boot_sel}, 2'b11);
    chk("R9 mapping reinit", addr_out, SRAM + 32'h10);
    flash_word0 = 32'h12; tick(2); look();
    chk("R3 no load no change", {31'd0, empty_flag}, 1);
    opt_load = 1; tick(1); opt_load = 0; look();
    chk("R3 empty cleared", {31'd0, empty_flag}, 0);
    boot_pin = 0; resample(); look();
    chk("R2 flash after clear", {30'd0, boot_sel}, 0);
    chk("R5 flash alias", addr_out, FLASH + 32'h10);
    tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule